// File: doc/BRIEF.md
# Low-Voltage Reset Sequencer

This block keeps a host processor in reset while its supply is unsafe and holds it there for a guaranteed settling time once the supply recovers. An external comparator provides a raw "supply above trip point" level, and the block samples it on a free-running clock. The block has three outputs to the rest of the system: a pull-down enable for an open-drain, weakly pulled-up reset line, a lockout flag for the serial bus engine, and a start grant for the memory engine.

The hold time is counted in clock cycles. The count restarts from zero if the supply dips again before the count ends. The raw supply level also passes through a two-flop synchronizer, so a change on it takes a fixed number of cycles to reach the outputs.

A memory operation may start only while the block is released. Once an operation has been granted, the block keeps its in-progress flag set until the memory engine reports completion. This holds even if the supply falls and bus lockout begins in the meantime.

Top module: `lv_reset_supervisor`

## Requirements
- R1: While `por_n` is low, and after it returns high with the supply still low, `rst_pull_low` is 1, `bus_lock` is 1, `mem_grant` is 0 even with `mem_req` high, and `mem_active` is 0.
- R2: When `supply_ok_raw` goes high with the block in reset, `rst_pull_low` stays 1 up to the (HOLD_CYCLES+2)th rising clock edge and is 0 after the (HOLD_CYCLES+3)th rising clock edge.
- R3: When `supply_ok_raw` falls while the block is released, `rst_pull_low` is still 0 after the second rising edge and is 1 after the third. A value of 1 on `rst_pull_low` means the line is pulled low. A value of 0 means the block does not drive the line, so the weak pull-up or another source sets its level.
- R4: If the supply indication falls during the hold period, even for a single cycle, the hold count restarts. Release then comes HOLD_CYCLES+3 edges after the last rise.
- R5: `bus_lock` is 1 in every cycle in which `rst_pull_low` is 1, and 0 otherwise.
- R6: `mem_grant` equals `mem_req` while the block is released and no operation is active. In every other cycle it is 0.
- R7: After a grant, `mem_active` is 1 from the next edge onward and stays 1 until the edge after `mem_done` is high. This holds whatever the supply or reset state. `mem_done` has no effect while no operation is active.
- R8: `mem_req` does not produce a second grant while `mem_active` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Asynchronous power-on clear, active low |
| supply_ok_raw | input | 1 | Comparator level, 1 = supply above trip point (asynchronous) |
| mem_req | input | 1 | Memory engine asks to start an operation |
| mem_done | input | 1 | Memory engine reports the current operation finished |
| rst_pull_low | output | 1 | 1 = pull the open-drain reset line low |
| bus_lock | output | 1 | 1 = serial bus activity blocked |
| mem_grant | output | 1 | Start of a memory operation allowed this cycle |
| mem_active | output | 1 | A granted memory operation is still in progress |

## Verification
Suppose the sequencer's state goes wrong. A reset release that is one cycle early or late, or a hold count that is not restarted after a dip, would show at `rst_pull_low` at the exact edge predicted from the last supply rise. The check therefore expects an edge-exact transition and not a time window. A lost or stray in-progress flag would show within one cycle: `mem_active` would drop before `mem_done`, or `mem_grant` would appear during lockout or during an active operation. Supply drops are placed before the hold ends, as single-cycle glitches, and during an active memory operation.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic [1:0] {
        ST_SUPPLY_LOW = 2'd0,
        ST_HOLD       = 2'd1,
        ST_RELEASED   = 2'd2
    } sup_state_e;

    typedef struct packed {
        sup_state_e state;
    } ctrl_regs_t;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/rsup_hold_timer.sv
module rsup_hold_timer #(
    parameter int LIMIT = 3_200_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic count_en,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (count_en) cnt_d = cnt_q + 1'b1;
        else          cnt_d = '0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == LAST);

    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        cnt_q <= LAST);

    // R4
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
        !count_en |=> cnt_q == '0);
endmodule

// File: rtl/rsup_mem_gate.sv
module rsup_mem_gate (
    input  logic clk,
    input  logic por_n,
    input  logic allow,
    input  logic mem_req,
    input  logic mem_done,
    output logic grant,
    output logic active
);
    logic active_d, active_q;

    always_comb begin
        grant = mem_req && allow && !active_q;
        if (active_q) active_d = !mem_done;
        else          active_d = grant;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) active_q <= 1'b0;
        else        active_q <= active_d;
    end

    assign active = active_q;

    // R7
    keep_active_chk: assert property (@(posedge clk) disable iff (!por_n)
        active_q && !mem_done |=> active_q);

    // R7
    grant_sets_chk: assert property (@(posedge clk) disable iff (!por_n)
        grant |=> active_q);
endmodule

// File: rtl/lv_reset_supervisor.sv
module lv_reset_supervisor #(
    parameter int HOLD_CYCLES = 3_200_000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok_raw,
    input  logic mem_req,
    input  logic mem_done,
    output logic rst_pull_low,
    output logic bus_lock,
    output logic mem_grant,
    output logic mem_active
);
    import rsup_pkg::*;

    logic       ok_s;
    logic       expired;
    logic       count_en;
    ctrl_regs_t r_d, r_q;

    rsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .din   (supply_ok_raw),
        .dout  (ok_s)
    );

    rsup_hold_timer #(.LIMIT(HOLD_CYCLES)) u_timer (
        .clk      (clk),
        .por_n    (por_n),
        .count_en (count_en),
        .expired  (expired)
    );

    always_comb begin
        r_d      = r_q;
        count_en = 1'b0;
        unique case (r_q.state)
            ST_SUPPLY_LOW: begin
                if (ok_s) r_d.state = ST_HOLD;
            end
            ST_HOLD: begin
                if (!ok_s)        r_d.state = ST_SUPPLY_LOW;
                else if (expired) r_d.state = ST_RELEASED;
                else              count_en  = 1'b1;
            end
            ST_RELEASED: begin
                if (!ok_s) r_d.state = ST_SUPPLY_LOW;
            end
            default: r_d.state = ST_SUPPLY_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q.state <= ST_SUPPLY_LOW;
        else        r_q       <= r_d;
    end

    assign rst_pull_low = (r_q.state != ST_RELEASED);
    assign bus_lock     = (r_q.state != ST_RELEASED);

    rsup_mem_gate u_gate (
        .clk      (clk),
        .por_n    (por_n),
        .allow    (r_q.state == ST_RELEASED),
        .mem_req  (mem_req),
        .mem_done (mem_done),
        .grant    (mem_grant),
        .active   (mem_active)
    );

    // R3
    fall_asserts_chk: assert property (@(posedge clk) disable iff (!por_n)
        r_q.state == ST_RELEASED && !ok_s |=> rst_pull_low);

    // R4
    hold_abort_chk: assert property (@(posedge clk) disable iff (!por_n)
        r_q.state == ST_HOLD && !ok_s |=> r_q.state == ST_SUPPLY_LOW);

    // R2
    no_skip_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        r_q.state == ST_SUPPLY_LOW |=> !expired || r_q.state != ST_RELEASED);

    // R2
    release_needs_count_chk: assert property (@(posedge clk) disable iff (!por_n)
        r_q.state == ST_SUPPLY_LOW |=> r_q.state != ST_RELEASED);

    // R8
    no_regrant_chk: assert property (@(posedge clk) disable iff (!por_n)
        mem_active |-> !mem_grant);
endmodule

// File: tb/lv_reset_supervisor_test.sv
module lv_reset_supervisor_test;
    localparam int H = 20;
    localparam int S_PULL = 0, S_LOCK = 1, S_GRANT = 2, S_ACT = 3;

    logic clk = 1'b0;
    logic por_n, supply_ok_raw, mem_req, mem_done;
    logic rst_pull_low, bus_lock, mem_grant, mem_active;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    int    q_cyc[$];
    int    q_sig[$];
    logic  q_val[$];
    string q_req[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lv_reset_supervisor #(.HOLD_CYCLES(H)) uut (
        .clk(clk), .por_n(por_n), .supply_ok_raw(supply_ok_raw),
        .mem_req(mem_req), .mem_done(mem_done),
        .rst_pull_low(rst_pull_low), .bus_lock(bus_lock),
        .mem_grant(mem_grant), .mem_active(mem_active)
    );

    task automatic expect_at(int dc, int sig, logic val, string req);
        q_cyc.push_back(cyc + dc);
        q_sig.push_back(sig);
        q_val.push_back(val);
        q_req.push_back(req);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic sample(int sig);
        case (sig)
            S_PULL:  return rst_pull_low;
            S_LOCK:  return bus_lock;
            S_GRANT: return mem_grant;
            default: return mem_active;
        endcase
    endfunction

    // monitor: pop and compare expected items due in the current cycle
    always @(negedge clk) begin
        #2;
        while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
            logic act;
            act = sample(q_sig[0]);
            checks++;
            if (q_cyc[0] < cyc || act !== q_val[0]) begin
                errors++;
                $display("FAIL %s sig=%0d actual=%b expected=%b cyc=%0d due=%0d",
                         q_req[0], q_sig[0], act, q_val[0], cyc, q_cyc[0]);
            end
            void'(q_cyc.pop_front());
            void'(q_sig.pop_front());
            void'(q_val.pop_front());
            void'(q_req.pop_front());
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; supply_ok_raw = 1'b0; mem_req = 1'b0; mem_done = 1'b0;
        step(3);
        // R1 reset state, request blocked
        mem_req = 1'b1;
        expect_at(0, S_PULL, 1'b1, "R1");
        expect_at(0, S_LOCK, 1'b1, "R1");
        expect_at(0, S_GRANT, 1'b0, "R1");
        expect_at(0, S_ACT, 1'b0, "R1");
        step(1);
        mem_req = 1'b0;
        por_n = 1'b1;
        step(3);
        expect_at(0, S_PULL, 1'b1, "R1");
        expect_at(0, S_LOCK, 1'b1, "R5");

        // R2 power-up release timing
        supply_ok_raw = 1'b1;
        expect_at(H + 2, S_PULL, 1'b1, "R2");
        expect_at(H + 2, S_LOCK, 1'b1, "R5");
        expect_at(H + 3, S_PULL, 1'b0, "R2");
        expect_at(H + 3, S_LOCK, 1'b0, "R5");
        step(H + 6);

        // R3 supply fall while released
        supply_ok_raw = 1'b0;
        expect_at(2, S_PULL, 1'b0, "R3");
        expect_at(3, S_PULL, 1'b1, "R3");
        expect_at(3, S_LOCK, 1'b1, "R5");
        step(6);

        // R4 dip during hold restarts the count
        supply_ok_raw = 1'b1;
        step(6);
        supply_ok_raw = 1'b0;
        step(4);
        supply_ok_raw = 1'b1;
        expect_at(H - 1, S_PULL, 1'b1, "R4");
        expect_at(H + 2, S_PULL, 1'b1, "R4");
        expect_at(H + 3, S_PULL, 1'b0, "R4");
        step(H + 5);

        // R4 single-cycle glitch while released
        supply_ok_raw = 1'b0;
        step(1);
        supply_ok_raw = 1'b1;
        expect_at(2, S_PULL, 1'b1, "R4");
        expect_at(H + 2, S_PULL, 1'b1, "R4");
        expect_at(H + 3, S_PULL, 1'b0, "R4");
        step(H + 5);

        // R6 grant while released and idle
        mem_req = 1'b1;
        expect_at(0, S_GRANT, 1'b1, "R6");
        step(1);
        // R7 active, R8 no second grant
        expect_at(0, S_ACT, 1'b1, "R7");
        expect_at(0, S_GRANT, 1'b0, "R8");
        step(1);
        mem_req = 1'b0;
        supply_ok_raw = 1'b0;
        expect_at(3, S_PULL, 1'b1, "R3");
        expect_at(3, S_ACT, 1'b1, "R7");
        expect_at(5, S_ACT, 1'b1, "R7");
        step(5);
        mem_done = 1'b1;
        expect_at(0, S_ACT, 1'b1, "R7");
        expect_at(1, S_ACT, 1'b0, "R7");
        step(1);
        mem_done = 1'b0;
        // R6 no grant during lockout even when idle
        mem_req = 1'b1;
        expect_at(0, S_GRANT, 1'b0, "R6");
        expect_at(2, S_ACT, 1'b0, "R6");
        step(2);
        mem_req = 1'b0;

        supply_ok_raw = 1'b1;
        expect_at(H + 3, S_PULL, 1'b0, "R2");
        step(H + 5);

        // R7 done while idle has no effect; then new grant and completion
        mem_done = 1'b1;
        expect_at(1, S_ACT, 1'b0, "R7");
        step(1);
        mem_done = 1'b0;
        mem_req = 1'b1;
        expect_at(0, S_GRANT, 1'b1, "R6");
        step(1);
        mem_req = 1'b0;
        mem_done = 1'b1;
        expect_at(0, S_ACT, 1'b1, "R7");
        expect_at(1, S_ACT, 1'b0, "R7");
        step(1);
        mem_done = 1'b0;
        step(3);

        if (q_cyc.size() != 0) begin
            errors++;
            $display("FAIL R1 pending actual=%0d expected=0", q_cyc.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule